// File: doc/BRIEF.md
# Power-management sleep control register

This block is one 32-bit control word for power management. Software reaches it through a plain I/O port at `BASE_ADDR + REG_OFS`. The word holds five fields:

- an interrupt-route select;
- a bus-master wake scratch bit;
- a global-release trigger that pulses an event toward firmware;
- a 3-bit sleep code;
- a sleep trigger.

When the sleep trigger is written together with a valid code, the block latches that code. It then drives either a processor-stop indicator or a cumulative set of active-low suspend lines. The latched state holds until the platform pulses the wake input.

The fields sit in three reset domains:

- the sleep code survives platform and core resets and is cleared only by the real-time-clock reset;
- the bus-master bit and the latched sleep state belong to the platform reset;
- the route select, the event pulse and the read path belong to the core reset.

Incoming power-management events are steered combinationally to the SCI output or the SMI output, according to the route select.

Top module: `pm_sleep_ctl`

## Requirements
- R1: With all three resets applied and released, the register reads 0. All suspend lines read 1 (idle), and `s1_o` and `gbl_evt_o` read 0.
- R2: Read layout: bit 0 is route select, bit 1 is bus-master wake and bits 12:10 are the sleep code. Bit 2 (global release), bit 13 (sleep trigger) and bits 9:3 and 31:14 always read 0.
- R3: Read data appears on `io_rdata` one cycle after a read strobe. A read issued in the same cycle as a write returns the value from before the write.
- R4: The sleep code is cleared only by `rtc_rst_n`. It is kept through `plat_rst_n` and `core_rst_n`.
- R5: `plat_rst_n` clears the bus-master bit. `core_rst_n` clears the route select.
- R6: Writing 1 to bit 2 drives `gbl_evt_o` high for exactly the one cycle after the write.
- R7: `bm_break_o` is high exactly when `bm_req` is high and the bus-master bit is 1.
- R8: With route select 1, `pm_evt` appears on `sci_o`. With route select 0, it appears on `smi_o`. The two are never high together.
- R9: A sleep-trigger write has the following effect, depending on the sleep code written in the same write:
  - code 101 drives `slp_s3_n` low;
  - code 110 drives `slp_s3_n` and `slp_s4_n` low;
  - code 111 drives all three suspend lines low.
  The lines change in the cycle after the write.
- R10: A sleep-trigger write with code 001 raises `s1_o` and leaves the suspend lines high. With code 000 nothing changes.
- R11: A sleep-trigger write with a reserved code (010, 011, 100) changes no sleep output.
- R12: A latched sleep state holds until `wake_i` pulses, which returns all sleep outputs to idle in the next cycle. Sleep-trigger writes made while a state is latched are ignored.
- R13: Writes to any other address change nothing. Reads from any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rtc_rst_n | input | 1 | RTC-domain reset, active low, clears the sleep code |
| plat_rst_n | input | 1 | Platform reset, active low, clears the bus-master bit and the sleep latch |
| core_rst_n | input | 1 | Core reset, active low, clears route select, event pulse and read data |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid the cycle after `io_rd` |
| pm_evt | input | 1 | Power-management event to route |
| bm_req | input | 1 | Bus-master request |
| wake_i | input | 1 | Wake pulse from the platform |
| sci_o | output | 1 | Event routed as SCI |
| smi_o | output | 1 | Event routed as SMI |
| bm_break_o | output | 1 | Bus-master request breaks the C3 state |
| gbl_evt_o | output | 1 | One-cycle global-release event toward firmware |
| s1_o | output | 1 | Processor-stop (S1) indicator |
| slp_s3_n | output | 1 | Suspend-to-RAM line, active low |
| slp_s4_n | output | 1 | Suspend-to-disk line, active low |
| slp_s5_n | output | 1 | Soft-off line, active low |

## Verification
The bench builds the block with `BASE_ADDR` = 16'h0500 and `REG_OFS` = 8, not the defaults. The register then answers at 16'h0508, while 16'h0504 serves as the neighbouring miss address. This shows that the decode follows both parameters rather than a fixed constant. With these values, the bench reaches the miss path for both writes (including a sleep trigger) and reads. It also reaches the three reset domains pulsed one at a time, and every sleep code including the reserved ones.

// File: rtl/pm_sleep_ctl.sv
module pm_sleep_ctl #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0400,
  parameter logic [ADDR_W-1:0] REG_OFS = 16'h0004
) (
  input  logic              clk,
  input  logic              rtc_rst_n,
  input  logic              plat_rst_n,
  input  logic              core_rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [31:0]       io_wdata,
  output logic [31:0]       io_rdata,
  input  logic              pm_evt,
  input  logic              bm_req,
  input  logic              wake_i,
  output logic              sci_o,
  output logic              smi_o,
  output logic              bm_break_o,
  output logic              gbl_evt_o,
  output logic              s1_o,
  output logic              slp_s3_n,
  output logic              slp_s4_n,
  output logic              slp_s5_n
);
  localparam logic [ADDR_W-1:0] REG_ADDR = BASE_ADDR + REG_OFS;
  localparam int B_ROUTE = 0;
  localparam int B_BMW   = 1;
  localparam int B_GBL   = 2;
  localparam int B_CODE  = 10;
  localparam int B_GO    = 13;

  logic       route_q, bmw_q, gbl_q;
  logic [2:0] code_q, held_q, next_code;
  logic       wr_hit, rd_hit, code_ok;
  logic [31:0] reg_val;
  wire unused_wdata = ^{io_wdata[31:14], io_wdata[9:3]};

  assign wr_hit    = io_wr && (io_addr == REG_ADDR);
  assign rd_hit    = io_rd && (io_addr == REG_ADDR);
  assign next_code = wr_hit ? io_wdata[B_CODE +: 3] : code_q;
  assign code_ok   = (next_code == 3'b001) || (next_code[2] && next_code[1:0] != 2'b00);
  assign reg_val   = {18'd0, 1'b0, code_q, 7'd0, 1'b0, bmw_q, route_q};

  always_ff @(posedge clk or negedge rtc_rst_n)
    if (!rtc_rst_n) code_q <= '0;
    else if (wr_hit) code_q <= io_wdata[B_CODE +: 3];

  always_ff @(posedge clk or negedge plat_rst_n)
    if (!plat_rst_n) begin
      bmw_q  <= 1'b0;
      held_q <= '0;
    end else begin
      if (wr_hit) bmw_q <= io_wdata[B_BMW];
      if (wake_i) held_q <= '0;
      else if (wr_hit && io_wdata[B_GO] && held_q == 3'b000 && code_ok)
        held_q <= next_code;
    end

  always_ff @(posedge clk or negedge core_rst_n)
    if (!core_rst_n) begin
      route_q  <= 1'b0;
      gbl_q    <= 1'b0;
      io_rdata <= '0;
    end else begin
      if (wr_hit) route_q <= io_wdata[B_ROUTE];
      gbl_q    <= wr_hit && io_wdata[B_GBL];
      io_rdata <= rd_hit ? reg_val : 32'd0;
    end

  assign gbl_evt_o  = gbl_q;
  assign sci_o      = pm_evt && route_q;
  assign smi_o      = pm_evt && !route_q;
  assign bm_break_o = bm_req && bmw_q;
  assign s1_o       = (held_q == 3'b001);
  assign slp_s3_n   = !(held_q[2] && held_q[1:0] != 2'b00);
  assign slp_s4_n   = !(held_q[2] && held_q[1]);
  assign slp_s5_n   = !(&held_q);
endmodule

// File: rtl/pm_sleep_ctl_chk.sv
module pm_sleep_ctl_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0404
) (
  input logic              clk,
  input logic              rst_all_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              wr_gbl,
  input logic [31:0]       io_rdata,
  input logic              wake_i,
  input logic              sci_o,
  input logic              smi_o,
  input logic              gbl_evt_o,
  input logic              s1_o,
  input logic              slp_s3_n,
  input logic              slp_s4_n,
  input logic              slp_s5_n
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_all_n)
    (io_rdata[31:13] == 19'd0) && (io_rdata[9:2] == 8'd0));

  p_gbl_cause_r6: assert property (@(posedge clk) disable iff (!rst_all_n)
    gbl_evt_o |-> $past(io_wr && io_addr == REG_ADDR && wr_gbl));

  p_route_excl_r8: assert property (@(posedge clk) disable iff (!rst_all_n)
    !(sci_o && smi_o));

  p_s4_needs_s3_r9: assert property (@(posedge clk) disable iff (!rst_all_n)
    !slp_s4_n |-> !slp_s3_n);

  p_s5_needs_s4_r9: assert property (@(posedge clk) disable iff (!rst_all_n)
    !slp_s5_n |-> !slp_s4_n);

  p_s1_alone_r10: assert property (@(posedge clk) disable iff (!rst_all_n)
    s1_o |-> slp_s3_n);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_all_n)
    (!slp_s3_n && !wake_i) |=> !slp_s3_n);

  p_wake_clears_r12: assert property (@(posedge clk) disable iff (!rst_all_n)
    wake_i |=> (slp_s3_n && slp_s4_n && slp_s5_n && !s1_o));
endmodule

bind pm_sleep_ctl pm_sleep_ctl_chk #(
  .ADDR_W(ADDR_W),
  .REG_ADDR(BASE_ADDR + REG_OFS)
) chk_i (
  .clk(clk),
  .rst_all_n(rtc_rst_n && plat_rst_n && core_rst_n),
  .io_addr(io_addr),
  .io_wr(io_wr),
  .wr_gbl(io_wdata[2]),
  .io_rdata(io_rdata),
  .wake_i(wake_i),
  .sci_o(sci_o),
  .smi_o(smi_o),
  .gbl_evt_o(gbl_evt_o),
  .s1_o(s1_o),
  .slp_s3_n(slp_s3_n),
  .slp_s4_n(slp_s4_n),
  .slp_s5_n(slp_s5_n)
);

// File: tb/pm_sleep_ctl_tb_top.sv
`timescale 1ns/1ps
module pm_sleep_ctl_tb_top;
  localparam logic [15:0] TB_BASE = 16'h0500;
  localparam logic [15:0] TB_OFS  = 16'h0008;
  localparam logic [15:0] HIT     = TB_BASE + TB_OFS;
  localparam logic [15:0] MISS    = 16'h0504;

  logic clk = 1'b0;
  logic rtc_rst_n = 1'b0, plat_rst_n = 1'b0, core_rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic pm_evt = 1'b0, bm_req = 1'b0, wake_i = 1'b0;
  logic sci_o, smi_o, bm_break_o, gbl_evt_o, s1_o, slp_s3_n, slp_s4_n, slp_s5_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pm_sleep_ctl #(.ADDR_W(16), .BASE_ADDR(TB_BASE), .REG_OFS(TB_OFS)) dut_i (
    .clk(clk), .rtc_rst_n(rtc_rst_n), .plat_rst_n(plat_rst_n), .core_rst_n(core_rst_n),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .pm_evt(pm_evt), .bm_req(bm_req), .wake_i(wake_i),
    .sci_o(sci_o), .smi_o(smi_o), .bm_break_o(bm_break_o), .gbl_evt_o(gbl_evt_o),
    .s1_o(s1_o), .slp_s3_n(slp_s3_n), .slp_s4_n(slp_s4_n), .slp_s5_n(slp_s5_n));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] slp();
    return {s1_o, slp_s5_n, slp_s4_n, slp_s3_n};
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0; io_wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; d = io_rdata;
  endtask

  task automatic wake();
    @(negedge clk); wake_i = 1'b1;
    @(negedge clk); wake_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(HIT, v);
    check("R1 readback", v, 32'h0);
    check("R1 sleep outputs", {28'd0, slp()}, 32'h7);
    check("R1 gbl", {31'd0, gbl_evt_o}, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] v;
    wr(HIT, 32'hFFFF_DFFF);
    check("R6 gbl pulse", {31'd0, gbl_evt_o}, 32'h1);
    @(negedge clk);
    check("R6 gbl single cycle", {31'd0, gbl_evt_o}, 32'h0);
    rd(HIT, v);
    check("R2 layout", v, 32'h0000_1C03);
    check("R2 no sleep from layout write", {28'd0, slp()}, 32'h7);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    wr(HIT, 32'h0000_0400);
    @(negedge clk); io_addr = HIT; io_wdata = 32'h0000_0001; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk); io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
    check("R3 read during write is old", io_rdata, 32'h0000_0400);
    rd(HIT, v);
    check("R3 read after write is new", v, 32'h0000_0001);
  endtask

  task automatic t_route();
    pm_evt = 1'b1;
    @(negedge clk);
    check("R8 route1 sci/smi", {30'd0, sci_o, smi_o}, 32'h2);
    wr(HIT, 32'h0);
    check("R8 route0 sci/smi", {30'd0, sci_o, smi_o}, 32'h1);
    pm_evt = 1'b0;
    @(negedge clk);
    check("R8 idle", {30'd0, sci_o, smi_o}, 32'h0);
  endtask

  task automatic t_bm();
    bm_req = 1'b1;
    @(negedge clk);
    check("R7 bm off", {31'd0, bm_break_o}, 32'h0);
    wr(HIT, 32'h2);
    check("R7 bm on", {31'd0, bm_break_o}, 32'h1);
    bm_req = 1'b0;
    @(negedge clk);
    check("R7 no request", {31'd0, bm_break_o}, 32'h0);
    wr(HIT, 32'h0);
  endtask

  task automatic t_reserved();
    for (int c = 2; c <= 4; c++) begin
      wr(HIT, 32'h2000 | (32'(c) << 10));
      @(negedge clk);
      check($sformatf("R11 reserved code %0d", c), {28'd0, slp()}, 32'h7);
    end
    wr(HIT, 32'h2000);
    check("R10 code 000 no change", {28'd0, slp()}, 32'h7);
  endtask

  task automatic t_s1();
    wr(HIT, 32'h2400);
    check("R10 S1", {28'd0, slp()}, 32'hF);
    wake();
    check("R12 wake from S1", {28'd0, slp()}, 32'h7);
  endtask

  task automatic t_sleep(input int c, input logic [3:0] exp);
    wr(HIT, 32'h2000 | (32'(c) << 10));
    check($sformatf("R9 code %0d", c), {28'd0, slp()}, {28'd0, exp});
    repeat (5) @(negedge clk);
    check($sformatf("R12 held code %0d", c), {28'd0, slp()}, {28'd0, exp});
    wr(HIT, 32'h2400);
    check($sformatf("R12 retrigger ignored code %0d", c), {28'd0, slp()}, {28'd0, exp});
    wake();
    check($sformatf("R12 wake code %0d", c), {28'd0, slp()}, 32'h7);
  endtask

  task automatic t_domains();
    logic [31:0] v;
    wr(HIT, 32'h0000_1403);
    @(negedge clk); plat_rst_n = 1'b0;
    @(negedge clk); plat_rst_n = 1'b1;
    rd(HIT, v);
    check("R5 platform reset clears bus-master bit", v, 32'h0000_1401);
    @(negedge clk); core_rst_n = 1'b0;
    @(negedge clk); core_rst_n = 1'b1;
    rd(HIT, v);
    check("R4 code kept through core reset, R5 route cleared", v, 32'h0000_1400);
    @(negedge clk); rtc_rst_n = 1'b0;
    @(negedge clk); rtc_rst_n = 1'b1;
    rd(HIT, v);
    check("R4 rtc reset clears code", v, 32'h0);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    wr(HIT, 32'h0000_0001);
    wr(MISS, 32'h0000_3C02);
    check("R13 miss write no sleep", {28'd0, slp()}, 32'h7);
    rd(HIT, v);
    check("R13 miss write ignored", v, 32'h0000_0001);
    rd(MISS, v);
    check("R13 miss read zero", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rtc_rst_n = 1'b1; plat_rst_n = 1'b1; core_rst_n = 1'b1;
    t_reset();
    t_layout();
    t_same_cycle();
    t_route();
    t_bm();
    t_reserved();
    t_s1();
    t_sleep(5, 4'b0110);
    t_sleep(6, 4'b0100);
    t_sleep(7, 4'b0000);
    t_domains();
    t_addr();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(8 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule